// File: doc/BRIEF.md
# Set-Associative Data Address Translation Buffer

This block holds recently used page translations for a load/store unit. A request's effective address is split into a page offset, a set index and a tag. The ways of the selected set are compared in parallel. On a hit, the stored page table entry supplies the real page number, the cache-inhibit attribute and the access rights. The block raises one flag per fault type. When translation is switched off, the effective address is passed straight through.

Entries come from a page-table walker through a write port. The way to replace is picked by a one-bit-per-set pseudo-LRU. That pseudo-LRU learns about a hit one cycle after the lookup, so a write in the cycle just after a hit still sees the older choice. An invalidate command either clears the single entry that matches its page number or, when either of its two select bits is set, clears the whole buffer.

All lookup results are combinational from the request. Writes, invalidations and reset act on the clock edge.

Top module: `dtlb_xlate`

## Requirements
- R1: The page is 4 KiB (PAGE_BITS=12). The set index is `ea[17:12]` (64 sets), and the tag is `ea[63:18]`. A lookup hits only when a valid way of that set holds the same tag, so another page that maps to the same set misses.
- R2: With `req_xlate`=0, `real_addr` equals `req_ea`, and `tlb_hit`, `cache_inh`, `f_miss`, `f_priv`, `f_perm` and `f_rc` are all 0.
- R3: On a hit, `real_addr` = {pte[63:12], ea[11:0]}, and `cache_inh` follows pte bit 0.
- R4: On a hit, `f_rc` is set when the reference bit (pte bit 4) is 0. For a store it is also set when the change bit (pte bit 5) is 0.
- R5: On a hit, `f_priv` is set when the privileged-only bit (pte bit 3) is 1 and `req_user`=1.
- R6: On a hit, `f_perm` is set for a store whose write bit (pte bit 1) is 0. It is set for a load when both the read bit (pte bit 2) and the write bit are 0.
- R7: A translated request that finds no entry sets `f_miss`, clears `tlb_hit`, and gives `real_addr`=0. `f_miss` and `tlb_hit` are never both set. The fault flags and `cache_inh` are 0 unless `tlb_hit`=1.
- R8: An invalidate with `inv_cmd[11:10]` nonzero clears every entry from the next cycle on.
- R9: An invalidate with `inv_cmd[11:10]`=0 clears only the entry whose page matches `inv_cmd[63:12]`. Other entries keep hitting, including an entry in the same set with a different tag.
- R10: Each set has a victim pointer that is reset to way 0. A translated hit points the victim of its set at the other way. The pointer is updated on the second clock edge after the lookup, so a write on the first edge after the hit still uses the old victim.
- R11: Reset clears all valid bits, so every translated lookup misses afterwards.
- R12: A write stores the entry into the victim way of its set, and it hits from the next cycle on. The other way of the set is left untouched. A write in the same cycle as an invalidate takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ea | input | 64 | Effective address of the request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user (unprivileged) state |
| req_xlate | input | 1 | 1 = translate, 0 = pass through |
| wr_valid | input | 1 | Write a new entry |
| wr_ea | input | 64 | Effective address whose page is written |
| wr_pte | input | 64 | Page table entry to store |
| inv_valid | input | 1 | Invalidate command present |
| inv_cmd | input | 64 | Invalidate command: page in [63:12], select in [11:10] |
| tlb_hit | output | 1 | Translated request hit |
| real_addr | output | 64 | Real address |
| cache_inh | output | 1 | Access is cache-inhibited |
| f_miss | output | 1 | Translation miss |
| f_priv | output | 1 | Privilege fault |
| f_perm | output | 1 | Read/write permission fault |
| f_rc | output | 1 | Reference/change fault |

## Verification
Lookup outputs are due in the same cycle as the request. The bench therefore drives each request just after a falling edge and samples one time unit later, before the next rising edge. Writes and invalidations are driven for exactly one rising edge, and the lookups that check them start at the falling edge after it. The pseudo-LRU result is checked only through which entries survive a later write. The bench places writes on the first and on the second edge after a hit, which shows both the lagging and the updated victim choice.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
   // attribute bit positions inside a stored page table entry
   localparam int ATTR_CI    = 0;
   localparam int ATTR_WR    = 1;
   localparam int ATTR_RD    = 2;
   localparam int ATTR_PRIV  = 3;
   localparam int ATTR_REF   = 4;
   localparam int ATTR_CHG   = 5;
   localparam int ATTR_W     = 6;
   // invalidate command select field
   localparam int INV_SEL_LSB = 10;
   localparam int INV_SEL_W   = 2;

   typedef struct packed {
      logic priv;
      logic perm;
      logic rc;
   } dtlb_fault_t;
endpackage

// File: rtl/dtlb_way_store.sv
module dtlb_way_store #(
   parameter int SETS  = 64,
   parameter int IDX_W = 6,
   parameter int TAG_W = 46,
   parameter int PTE_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_vld,
   output logic [TAG_W-1:0] rd_tag,
   output logic [PTE_W-1:0] rd_pte,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PTE_W-1:0] wr_pte,
   input  logic             inv_all,
   input  logic             inv_one,
   input  logic [IDX_W-1:0] inv_idx,
   input  logic [TAG_W-1:0] inv_tag
);
   logic [SETS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [SETS];
   logic [PTE_W-1:0] pte_q [SETS];

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else begin
         if (inv_all) begin
            vld_q <= '0;
         end else if (inv_one && vld_q[inv_idx] && (tag_q[inv_idx] == inv_tag)) begin
            vld_q[inv_idx] <= 1'b0;
         end
         if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         pte_q[wr_idx] <= wr_pte;
      end
   end

   assign rd_vld = vld_q[rd_idx];
   assign rd_tag = tag_q[rd_idx];
   assign rd_pte = pte_q[rd_idx];
endmodule

// File: rtl/dtlb_plru.sv
module dtlb_plru #(
   parameter int SETS  = 64,
   parameter int IDX_W = 6,
   parameter int WAYS  = 2,
   parameter int WAY_W = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit_v,
   input  logic [IDX_W-1:0] hit_idx,
   input  logic [WAY_W-1:0] hit_way,
   input  logic [IDX_W-1:0] vic_idx,
   output logic [WAY_W-1:0] victim
);
   generate
      if (WAYS == 1) begin : g_one
         logic unused_plru;
         assign unused_plru = ^{clk, rst, hit_v, hit_idx, hit_way, vic_idx};
         assign victim = '0;
      end else if (WAYS == 2) begin : g_two
         logic [SETS-1:0]  vic_q;
         logic             upd_v;
         logic [IDX_W-1:0] upd_idx;
         logic             upd_way;

         // register stage between tag match and replacement state
         always_ff @(posedge clk) begin
            if (rst) begin
               upd_v <= 1'b0;
               vic_q <= '0;
            end else begin
               upd_v <= hit_v;
               if (upd_v) vic_q[upd_idx] <= ~upd_way;
            end
         end

         always_ff @(posedge clk) begin
            upd_idx <= hit_idx;
            upd_way <= hit_way[0];
         end

         assign victim = vic_q[vic_idx];
      end else begin : g_bad
         $error("dtlb_plru: WAYS must be 1 or 2");
      end
   endgenerate
endmodule

// File: rtl/dtlb_perm.sv
module dtlb_perm
   import dtlb_pkg::*;
(
   input  logic              [ATTR_W-1:0] attr,
   input  logic                           is_store,
   input  logic                           user_mode,
   output dtlb_fault_t                    fault,
   output logic                           inhibit
);
   always_comb begin
      fault.rc   = ~attr[ATTR_REF] | (is_store & ~attr[ATTR_CHG]);
      fault.priv = attr[ATTR_PRIV] & user_mode;
      fault.perm = is_store ? ~attr[ATTR_WR] : ~(attr[ATTR_RD] | attr[ATTR_WR]);
      inhibit    = attr[ATTR_CI];
   end
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
   import dtlb_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int PAGE_BITS = 12,
   parameter int SETS      = 64,
   parameter int WAYS      = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_ea,
   input  logic              req_store,
   input  logic              req_user,
   input  logic              req_xlate,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_ea,
   input  logic [ADDR_W-1:0] wr_pte,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_cmd,
   output logic              tlb_hit,
   output logic [ADDR_W-1:0] real_addr,
   output logic              cache_inh,
   output logic              f_miss,
   output logic              f_priv,
   output logic              f_perm,
   output logic              f_rc
);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - PAGE_BITS - IDX_W;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int RPN_W = ADDR_W - PAGE_BITS;
   localparam int TAG_LSB = PAGE_BITS + IDX_W;

   generate
      if (PAGE_BITS < INV_SEL_LSB + INV_SEL_W) begin : g_chk_page
         $error("dtlb_xlate: PAGE_BITS too small for the invalidate select field");
      end
      if ((SETS & (SETS - 1)) != 0) begin : g_chk_sets
         $error("dtlb_xlate: SETS must be a power of two");
      end
      if (TAG_W < 1) begin : g_chk_tag
         $error("dtlb_xlate: address too narrow for the set index");
      end
   endgenerate

   // address split
   logic [IDX_W-1:0] req_idx, wr_idx, inv_idx;
   logic [TAG_W-1:0] req_tag, wr_tag, inv_tag;
   assign req_idx = req_ea[PAGE_BITS +: IDX_W];
   assign req_tag = req_ea[ADDR_W-1:TAG_LSB];
   assign wr_idx  = wr_ea[PAGE_BITS +: IDX_W];
   assign wr_tag  = wr_ea[ADDR_W-1:TAG_LSB];
   assign inv_idx = inv_cmd[PAGE_BITS +: IDX_W];
   assign inv_tag = inv_cmd[ADDR_W-1:TAG_LSB];

   logic inv_all, inv_one;
   assign inv_all = inv_valid & (|inv_cmd[INV_SEL_LSB +: INV_SEL_W]);
   assign inv_one = inv_valid & ~(|inv_cmd[INV_SEL_LSB +: INV_SEL_W]);

   logic [WAY_W-1:0]  victim;
   logic [WAYS-1:0]   way_vld;
   logic [TAG_W-1:0]  way_tag [WAYS];
   logic [ADDR_W-1:0] way_pte [WAYS];
   logic [WAYS-1:0]   way_match;

   generate
      for (genvar g = 0; g < WAYS; g++) begin : g_way
         dtlb_way_store #(
            .SETS (SETS),
            .IDX_W(IDX_W),
            .TAG_W(TAG_W),
            .PTE_W(ADDR_W)
         ) u_store (
            .clk    (clk),
            .rst    (rst),
            .rd_idx (req_idx),
            .rd_vld (way_vld[g]),
            .rd_tag (way_tag[g]),
            .rd_pte (way_pte[g]),
            .wr_en  (wr_valid && (victim == WAY_W'(g))),
            .wr_idx (wr_idx),
            .wr_tag (wr_tag),
            .wr_pte (wr_pte),
            .inv_all(inv_all),
            .inv_one(inv_one),
            .inv_idx(inv_idx),
            .inv_tag(inv_tag)
         );
         assign way_match[g] = way_vld[g] && (way_tag[g] == req_tag);
      end
   endgenerate

   // way select: lowest matching way wins
   logic              any_hit;
   logic [WAY_W-1:0]  hit_way;
   logic [ADDR_W-1:0] sel_pte;
   always_comb begin
      any_hit = 1'b0;
      hit_way = '0;
      sel_pte = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (way_match[w]) begin
            any_hit = 1'b1;
            hit_way = WAY_W'(w);
            sel_pte = way_pte[w];
         end
      end
   end

   dtlb_plru #(
      .SETS (SETS),
      .IDX_W(IDX_W),
      .WAYS (WAYS),
      .WAY_W(WAY_W)
   ) u_plru (
      .clk    (clk),
      .rst    (rst),
      .hit_v  (req_valid && req_xlate && any_hit),
      .hit_idx(req_idx),
      .hit_way(hit_way),
      .vic_idx(wr_idx),
      .victim (victim)
   );

   dtlb_fault_t fault;
   logic        inhibit;
   dtlb_perm u_perm (
      .attr     (sel_pte[ATTR_W-1:0]),
      .is_store (req_store),
      .user_mode(req_user),
      .fault    (fault),
      .inhibit  (inhibit)
   );

   logic xl_req;
   logic [RPN_W-1:0] rpn;
   assign xl_req = req_valid & req_xlate;
   assign rpn    = sel_pte[ADDR_W-1:PAGE_BITS];

   always_comb begin
      tlb_hit   = xl_req & any_hit;
      f_miss    = xl_req & ~any_hit;
      f_priv    = tlb_hit & fault.priv;
      f_perm    = tlb_hit & fault.perm;
      f_rc      = tlb_hit & fault.rc;
      cache_inh = tlb_hit & inhibit;
      if (!req_xlate)   real_addr = req_ea;
      else if (any_hit) real_addr = {rpn, req_ea[PAGE_BITS-1:0]};
      else              real_addr = '0;
   end

   logic unused_bits;
   assign unused_bits = ^{wr_ea[PAGE_BITS-1:0], inv_cmd[PAGE_BITS-1:0],
                          sel_pte[PAGE_BITS-1:ATTR_W]};
endmodule

// File: rtl/dtlb_xlate_chk.sv
module dtlb_xlate_chk #(
   parameter int ADDR_W    = 64,
   parameter int PAGE_BITS = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_ea,
   input logic              req_xlate,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_ea,
   input logic              inv_valid,
   input logic [ADDR_W-1:0] inv_cmd,
   input logic              tlb_hit,
   input logic [ADDR_W-1:0] real_addr,
   input logic              cache_inh,
   input logic              f_miss,
   input logic              f_priv,
   input logic              f_perm,
   input logic              f_rc
);
   localparam int SEL_LSB = dtlb_pkg::INV_SEL_LSB;
   localparam int SEL_W   = dtlb_pkg::INV_SEL_W;

   a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_xlate) |->
         (real_addr == req_ea) && !tlb_hit && !f_miss && !f_priv && !f_perm && !f_rc && !cache_inh);

   a_r7_hit_xor_miss: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_xlate) |-> (tlb_hit != f_miss));

   a_r7_flags_need_hit: assert property (@(posedge clk) disable iff (rst)
      (f_priv || f_perm || f_rc || cache_inh) |-> tlb_hit);

   a_r11_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && req_valid && req_xlate) |-> f_miss);

   a_r8_inv_all_clears: assert property (@(posedge clk) disable iff (rst)
      ($past(inv_valid && (|inv_cmd[SEL_LSB +: SEL_W]) && !wr_valid) && req_valid && req_xlate)
         |-> f_miss);

   a_r12_write_then_hit: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_valid && !rst) && req_valid && req_xlate &&
       (req_ea[ADDR_W-1:PAGE_BITS] == $past(wr_ea[ADDR_W-1:PAGE_BITS]))) |-> tlb_hit);
endmodule

bind dtlb_xlate dtlb_xlate_chk #(
   .ADDR_W   (ADDR_W),
   .PAGE_BITS(PAGE_BITS)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .req_valid(req_valid),
   .req_ea   (req_ea),
   .req_xlate(req_xlate),
   .wr_valid (wr_valid),
   .wr_ea    (wr_ea),
   .inv_valid(inv_valid),
   .inv_cmd  (inv_cmd),
   .tlb_hit  (tlb_hit),
   .real_addr(real_addr),
   .cache_inh(cache_inh),
   .f_miss   (f_miss),
   .f_priv   (f_priv),
   .f_perm   (f_perm),
   .f_rc     (f_rc)
);

// File: tb/sim_dtlb_xlate.sv
`timescale 1ns/1ps
module sim_dtlb_xlate;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0, req_store = 1'b0, req_user = 1'b0, req_xlate = 1'b0;
   logic [63:0] req_ea = '0;
   logic        wr_valid = 1'b0;
   logic [63:0] wr_ea = '0, wr_pte = '0;
   logic        inv_valid = 1'b0;
   logic [63:0] inv_cmd = '0;
   logic        tlb_hit, cache_inh, f_miss, f_priv, f_perm, f_rc;
   logic [63:0] real_addr;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dtlb_xlate u0 (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ea(req_ea), .req_store(req_store),
      .req_user(req_user), .req_xlate(req_xlate),
      .wr_valid(wr_valid), .wr_ea(wr_ea), .wr_pte(wr_pte),
      .inv_valid(inv_valid), .inv_cmd(inv_cmd),
      .tlb_hit(tlb_hit), .real_addr(real_addr), .cache_inh(cache_inh),
      .f_miss(f_miss), .f_priv(f_priv), .f_perm(f_perm), .f_rc(f_rc)
   );

   // expected result: {hit, miss, priv, perm, rc, ci, ra}
   function automatic logic [69:0] ex(logic h, logic m, logic p, logic pm, logic rc,
                                      logic ci, logic [63:0] ra);
      return {h, m, p, pm, rc, ci, ra};
   endfunction

   typedef struct packed {
      logic [63:0] ea;
      logic        st;
      logic        usr;
      logic        xl;
      logic [7:0]  req;
      logic [69:0] exp;
   } vec_t;

   // pages k=1..7 live in sets 1..7, real page 0xAA000+k
   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{64'h1001123, 1'b0, 1'b1, 1'b1, 8'd3, ex(1,0,0,0,0,0,64'hAA001123)}, // R3 clean load
      '{64'h1001123, 1'b1, 1'b1, 1'b1, 8'd6, ex(1,0,0,0,0,0,64'hAA001123)}, // R6 clean store
      '{64'h2002123, 1'b0, 1'b0, 1'b1, 8'd4, ex(1,0,0,0,0,0,64'hAA002123)}, // R4 load ok w/o change
      '{64'h2002123, 1'b1, 1'b0, 1'b1, 8'd4, ex(1,0,0,0,1,0,64'hAA002123)}, // R4 store needs change
      '{64'h3003123, 1'b0, 1'b0, 1'b1, 8'd5, ex(1,0,0,0,0,0,64'hAA003123)}, // R5 supervisor ok
      '{64'h3003123, 1'b0, 1'b1, 1'b1, 8'd5, ex(1,0,1,0,0,0,64'hAA003123)}, // R5 user load
      '{64'h3003123, 1'b1, 1'b1, 1'b1, 8'd5, ex(1,0,1,0,0,0,64'hAA003123)}, // R5 user store
      '{64'h4004123, 1'b1, 1'b0, 1'b1, 8'd6, ex(1,0,0,1,0,0,64'hAA004123)}, // R6 store no write bit
      '{64'h4004123, 1'b0, 1'b0, 1'b1, 8'd6, ex(1,0,0,0,0,0,64'hAA004123)}, // R6 load read bit
      '{64'h5005123, 1'b0, 1'b0, 1'b1, 8'd6, ex(1,0,0,0,0,0,64'hAA005123)}, // R6 load via write bit
      '{64'h5005123, 1'b1, 1'b0, 1'b1, 8'd6, ex(1,0,0,0,0,0,64'hAA005123)}, // R6 store write bit
      '{64'h6006123, 1'b0, 1'b0, 1'b1, 8'd4, ex(1,0,0,0,1,1,64'hAA006123)}, // R4 no reference, R3 ci
      '{64'h6006123, 1'b1, 1'b0, 1'b1, 8'd4, ex(1,0,0,0,1,1,64'hAA006123)}, // R4 store no reference
      '{64'h7007123, 1'b0, 1'b0, 1'b1, 8'd6, ex(1,0,0,1,0,0,64'hAA007123)}, // R6 load no rights
      '{64'h7007123, 1'b1, 1'b0, 1'b1, 8'd6, ex(1,0,0,1,0,0,64'hAA007123)}, // R6 store no rights
      '{64'h8001123, 1'b0, 1'b0, 1'b1, 8'd1, ex(0,1,0,0,0,0,64'h0)},        // R1 same set, other tag
      '{64'hDEADBEEF00001234, 1'b0, 1'b0, 1'b0, 8'd2,
        ex(0,0,0,0,0,0,64'hDEADBEEF00001234)},                              // R2 pass through
      '{64'h0000000000000FFF, 1'b1, 1'b1, 1'b0, 8'd2,
        ex(0,0,0,0,0,0,64'h0000000000000FFF)}                               // R2 store pass through
   };

   function automatic logic [63:0] pte(int k, logic [5:0] attr);
      return ((64'hAA000 + 64'(k)) << 12) | {58'd0, attr};
   endfunction

   task automatic check(int req, logic [69:0] exp);
      logic [69:0] got;
      got = {tlb_hit, f_miss, f_priv, f_perm, f_rc, cache_inh, real_addr};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d got=%h exp=%h", req, got, exp);
      end
   endtask

   // each op starts at a falling edge and spans one rising edge
   task automatic op_write(logic [63:0] page, logic [63:0] p);
      wr_valid = 1'b1; wr_ea = page << 12; wr_pte = p;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic op_inv(logic [63:0] cmd);
      inv_valid = 1'b1; inv_cmd = cmd;
      @(negedge clk);
      inv_valid = 1'b0;
   endtask

   task automatic op_look(logic [63:0] ea, logic st, logic usr, logic xl,
                          int req, logic [69:0] exp);
      req_valid = 1'b1; req_ea = ea; req_store = st; req_user = usr; req_xlate = xl;
      #1;
      check(req, exp);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [69:0] hit_ok(int k);
      return ex(1,0,0,0,0,0, ((64'hAA000 + 64'(k)) << 12) | 64'h123);
   endfunction
   localparam logic [69:0] MISS = {6'b010000, 64'h0};

   initial begin
      repeat (3) @(negedge clk);
      // R11 idle outputs during reset
      #1 check(11, ex(0,0,0,0,0,0,64'h0));
      @(negedge clk);
      rst = 1'b0;
      // R11 empty after reset
      op_look(64'h1001123, 1'b0, 1'b0, 1'b1, 11, MISS);

      op_write(64'h1001, pte(1, 6'h36));
      op_write(64'h2002, pte(2, 6'h16));
      op_write(64'h3003, pte(3, 6'h3E));
      op_write(64'h4004, pte(4, 6'h34));
      op_write(64'h5005, pte(5, 6'h32));
      op_write(64'h6006, pte(6, 6'h27));
      op_write(64'h7007, pte(7, 6'h30));

      for (int i = 0; i < NV; i++)
         op_look(VEC[i].ea, VEC[i].st, VEC[i].usr, VEC[i].xl, int'(VEC[i].req), VEC[i].exp);

      // R9 single invalidate: only the matching page
      op_inv(64'h1001 << 12);
      op_look(64'h1001123, 1'b0, 1'b0, 1'b1, 9, MISS);
      op_look(64'h2002123, 1'b0, 1'b0, 1'b1, 9, hit_ok(2));
      op_inv(64'h9002 << 12);          // same set, other tag: nothing cleared
      op_look(64'h2002123, 1'b0, 1'b0, 1'b1, 9, hit_ok(2));

      // R8 invalidate all via bit 10, then via bit 11
      op_inv(64'h2002000 | 64'h400);
      op_look(64'h2002123, 1'b0, 1'b0, 1'b1, 8, MISS);
      op_look(64'h4004123, 1'b0, 1'b0, 1'b1, 8, MISS);
      op_write(64'h1001, pte(1, 6'h36));
      op_look(64'h1001123, 1'b0, 1'b0, 1'b1, 12, hit_ok(1));
      op_inv(64'h800);
      op_look(64'h1001123, 1'b0, 1'b0, 1'b1, 8, MISS);

      // R10 replacement lag, set 10
      op_write(64'h100A, pte(1, 6'h36));               // way 0
      op_look(64'h100A123, 1'b0, 1'b0, 1'b1, 12, hit_ok(1));
      op_write(64'h200A, pte(2, 6'h36));               // old victim: way 0 again
      op_look(64'h100A123, 1'b0, 1'b0, 1'b1, 10, MISS);
      op_look(64'h200A123, 1'b0, 1'b0, 1'b1, 10, hit_ok(2));
      @(negedge clk);                                  // let the update land
      op_write(64'h300A, pte(3, 6'h36));               // victim now way 1
      op_look(64'h200A123, 1'b0, 1'b0, 1'b1, 12, hit_ok(2));
      op_look(64'h300A123, 1'b0, 1'b0, 1'b1, 10, hit_ok(3));
      @(negedge clk);
      op_write(64'h400A, pte(4, 6'h36));               // last hit way 1 -> replace way 0
      op_look(64'h400A123, 1'b0, 1'b0, 1'b1, 10, hit_ok(4));
      op_look(64'h300A123, 1'b0, 1'b0, 1'b1, 12, hit_ok(3));
      op_look(64'h200A123, 1'b0, 1'b0, 1'b1, 10, MISS);

      // R11 reset mid-run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      op_look(64'h400A123, 1'b0, 1'b0, 1'b1, 11, MISS);
      op_look(64'h300A123, 1'b0, 1'b0, 1'b1, 11, MISS);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule